// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the strobe and address timing that an 8051-class core needs to reach memory outside the chip. It divides the oscillator into machine cycles of 12 or 6 oscillator periods, as chosen by a mode input. Each machine cycle has two halves. Each half has three equal sub-phases: an address-latch pulse, an address hold, and a strobe window. In every half where the core asks for a code byte and the external-access pin is low, the block drives the fetch address and pulses the program strobe.

When the core asks for a data access at a machine-cycle boundary, the next machine cycle becomes a data cycle. The first half carries the address latch pulse as usual. The second pulse is dropped, and both program strobes are withheld. The read or write strobe covers the rest of the cycle. The high address byte comes from the data pointer for 16-bit accesses and from the port-2 register contents for 8-bit accesses.

A qualifier watches the reset pin once per machine cycle. It raises the core reset only after the pin has been high at eight boundaries in a row. While the core reset is high, the block issues no bus activity.

Top module: `ext_bus_seq`

## Requirements
- R1: With no data cycle and the core out of reset, `ale` rises twice per machine cycle, at the start of each half, and stays high for one sub-phase. A sub-phase is 2 oscillator clocks when `mode6` is 0 (12-clock cycle) and 1 clock when `mode6` is 1 (6-clock cycle).
- R2: `mode6` is sampled only at the last clock of a machine cycle. A change in mid-cycle does not alter the length of the current cycle.
- R3: A machine cycle that performs a data access has exactly one `ale` pulse, in its first half, and `psen_n` stays high for the whole cycle.
- R4: If `ea_n` is 0 and `fetch_req` is 1 at the start of a half of a non-data cycle, `psen_n` is low during the third sub-phase of that half. This gives two pulses per machine cycle.
- R5: If `ea_n` is 1, `psen_n` never goes low.
- R6: `hi_addr` shows `data_addr[15:8]` in a data cycle with `data_wide`=1, and `p2_latch` in a data cycle with `data_wide`=0. It shows `fetch_addr[15:8]` in a half doing an external fetch, and `p2_latch` otherwise.
- R7: In a fetch half or a data cycle, `ad_oe` is 1 and `ad_out` shows the low address byte while `ale` is high and during the following sub-phase. `ale` falls at least one clock before the low port is released.
- R8: A data read (`data_we`=0) holds `rd_n` low, and a write holds `wr_n` low, from the third sub-phase to the end of the cycle. `rd_n` and `wr_n` are never low together. During a write, `ad_oe` stays 1 and `ad_out` shows `data_wdata` in the strobe window.
- R9: At the clock where a program or read strobe ends, `ad_in` is captured into `rd_byte`, and `rd_valid` is high for exactly one clock after it.
- R10: `core_rst` rises after `rst_pin` has been high at 8 consecutive machine-cycle boundaries. One boundary with `rst_pin` low clears both the count and `core_rst`. While `core_rst` is 1, `ale`, `psen_n`, `rd_n` and `wr_n` stay idle.
- R11: After `arst_n` is asserted, `core_rst` is 1 and all strobes are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Power-on reset, active low |
| mode6 | input | 1 | 1: 6 clocks per machine cycle, 0: 12 |
| ea_n | input | 1 | External access pin, low sends code fetches off-chip |
| rst_pin | input | 1 | Reset pin, qualified over machine cycles |
| fetch_req | input | 1 | Core wants a code byte in the coming half |
| fetch_addr | input | 16 | Code address |
| data_req | input | 1 | Core wants a data access in the next machine cycle |
| data_we | input | 1 | 1 write, 0 read |
| data_wide | input | 1 | 1: 16-bit pointer, 0: 8-bit register-indirect |
| data_addr | input | 16 | Data address |
| data_wdata | input | 8 | Write byte |
| p2_latch | input | 8 | Port-2 register contents |
| ad_in | input | 8 | Low port input from the pins |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low port output: address then data |
| ad_oe | output | 1 | Low port strong drive enable |
| hi_addr | output | 8 | High port output |
| rd_byte | output | 8 | Byte captured at strobe end |
| rd_valid | output | 1 | One-clock pulse, `rd_byte` is new |
| core_rst | output | 1 | Qualified reset to the core |
| mcyc_start | output | 1 | High on the first clock of each machine cycle |

## Verification
The hardest case to reach from the ports is a mode change that lands in the middle of a machine cycle. It has to be shown that the running cycle keeps its old length and only the next one switches. The bench locks onto `mcyc_start`, flips `mode6` a few clocks later, and measures the lengths of the current and next cycles. A second hard case is a reset pulse that is one boundary too short. It is produced by holding `rst_pin` for seven boundaries, dropping it for one, and then raising it again. This shows that the count restarts and does not resume.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_FETCH = 2'd1,
        K_DRD   = 2'd2,
        K_DWR   = 2'd3
    } xb_kind_e;

    localparam int BYTE_W = 8;

    typedef struct packed {
        xb_kind_e            kind;
        logic                use_p2;
        logic [BYTE_W-1:0]   lo;
        logic [BYTE_W-1:0]   hi;
        logic [BYTE_W-1:0]   wdata;
        logic [BYTE_W-1:0]   rbyte;
        logic                rvalid;
    } xb_ctl_t;

endpackage

// File: rtl/ext_bus_timer.sv
module ext_bus_timer #(
    parameter int PH_W = 3
) (
    input  logic            clk,
    input  logic            arst_n,
    input  logic            mode6,
    output logic [PH_W-1:0] ph,
    output logic            tick_last,
    output logic            half_end,
    output logic            mc_end,
    output logic            mc_first
);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(5);

    typedef struct packed {
        logic            sub;
        logic [PH_W-1:0] ph;
        logic            m6;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        tick_last = s_q.m6 | s_q.sub;
        if (tick_last) begin
            s_d.sub = 1'b0;
            if (s_q.ph == PH_LAST) begin
                s_d.ph = '0;
                s_d.m6 = mode6;
            end else begin
                s_d.ph = s_q.ph + PH_W'(1);
            end
        end else begin
            s_d.sub = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ph       = s_q.ph;
    assign half_end = tick_last && (s_q.ph == PH_HALF);
    assign mc_end   = tick_last && (s_q.ph == PH_LAST);
    assign mc_first = (s_q.ph == '0) && !s_q.sub;
endmodule

// File: rtl/ext_bus_rstq.sv
module ext_bus_rstq #(
    parameter int RST_MC = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic mc_end,
    input  logic rst_pin,
    output logic rst_next,
    output logic core_rst
);
    localparam int CW = $clog2(RST_MC + 1);
    localparam logic [CW-1:0] CMAX = CW'(RST_MC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rst;
    } rq_t;

    rq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (mc_end) begin
            if (rst_pin) begin
                if (r_q.cnt != CMAX) r_d.cnt = r_q.cnt + CW'(1);
                r_d.rst = (r_d.cnt == CMAX);
            end else begin
                r_d.cnt = '0;
                r_d.rst = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r_q <= '{cnt: CMAX, rst: 1'b1};
        else         r_q <= r_d;
    end

    assign rst_next = r_d.rst;
    assign core_rst = r_q.rst;
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ext_bus_pkg::*;
#(
    parameter int RST_MC = 8
) (
    input  logic                 clk,
    input  logic                 arst_n,
    input  logic                 mode6,
    input  logic                 ea_n,
    input  logic                 rst_pin,
    input  logic                 fetch_req,
    input  logic [2*BYTE_W-1:0]  fetch_addr,
    input  logic                 data_req,
    input  logic                 data_we,
    input  logic                 data_wide,
    input  logic [2*BYTE_W-1:0]  data_addr,
    input  logic [BYTE_W-1:0]    data_wdata,
    input  logic [BYTE_W-1:0]    p2_latch,
    input  logic [BYTE_W-1:0]    ad_in,
    output logic                 ale,
    output logic                 psen_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic [BYTE_W-1:0]    ad_out,
    output logic                 ad_oe,
    output logic [BYTE_W-1:0]    hi_addr,
    output logic [BYTE_W-1:0]    rd_byte,
    output logic                 rd_valid,
    output logic                 core_rst,
    output logic                 mcyc_start
);
    localparam int PH_W = 3;
    localparam logic [PH_W-1:0] PH_STROBE0 = PH_W'(2);
    localparam logic [PH_W-1:0] PH_HALF1   = PH_W'(3);
    localparam logic [PH_W-1:0] PH_LAST    = PH_W'(5);

    logic [PH_W-1:0] ph;
    logic            tick_last, half_end, mc_end, rst_next;

    ext_bus_timer #(.PH_W(PH_W)) u_tmr (
        .clk       (clk),
        .arst_n    (arst_n),
        .mode6     (mode6),
        .ph        (ph),
        .tick_last (tick_last),
        .half_end  (half_end),
        .mc_end    (mc_end),
        .mc_first  (mcyc_start)
    );

    ext_bus_rstq #(.RST_MC(RST_MC)) u_rstq (
        .clk      (clk),
        .arst_n   (arst_n),
        .mc_end   (mc_end),
        .rst_pin  (rst_pin),
        .rst_next (rst_next),
        .core_rst (core_rst)
    );

    xb_ctl_t c_d, c_q;
    logic    is_data, half1, ext_fetch;
    logic [PH_W-1:0] sph;

    assign ext_fetch = !ea_n && fetch_req;

    always_comb begin
        c_d        = c_q;
        c_d.rvalid = 1'b0;
        if (tick_last &&
            ((c_q.kind == K_FETCH && (ph == PH_STROBE0 || ph == PH_LAST)) ||
             (c_q.kind == K_DRD && ph == PH_LAST))) begin
            c_d.rbyte  = ad_in;
            c_d.rvalid = 1'b1;
        end
        if (mc_end) begin
            c_d.use_p2 = 1'b1;
            c_d.kind   = K_NONE;
            if (!rst_next) begin
                if (data_req) begin
                    c_d.kind   = data_we ? K_DWR : K_DRD;
                    c_d.lo     = data_addr[BYTE_W-1:0];
                    c_d.hi     = data_addr[2*BYTE_W-1:BYTE_W];
                    c_d.use_p2 = !data_wide;
                    c_d.wdata  = data_wdata;
                end else if (ext_fetch) begin
                    c_d.kind   = K_FETCH;
                    c_d.lo     = fetch_addr[BYTE_W-1:0];
                    c_d.hi     = fetch_addr[2*BYTE_W-1:BYTE_W];
                    c_d.use_p2 = 1'b0;
                end
            end
        end else if (half_end && c_q.kind != K_DRD && c_q.kind != K_DWR) begin
            c_d.use_p2 = 1'b1;
            c_d.kind   = K_NONE;
            if (!core_rst && ext_fetch) begin
                c_d.kind   = K_FETCH;
                c_d.lo     = fetch_addr[BYTE_W-1:0];
                c_d.hi     = fetch_addr[2*BYTE_W-1:BYTE_W];
                c_d.use_p2 = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) c_q <= '{kind: K_NONE, use_p2: 1'b1, default: '0};
        else         c_q <= c_d;
    end

    // Output decode from registered phase and cycle kind.
    always_comb begin
        is_data = (c_q.kind == K_DRD) || (c_q.kind == K_DWR);
        half1   = (ph >= PH_HALF1);
        sph     = half1 ? ph - PH_HALF1 : ph;
        ale     = !core_rst && (sph == '0) && !(is_data && half1);
        psen_n  = !((c_q.kind == K_FETCH) && (sph == PH_STROBE0));
        rd_n    = !((c_q.kind == K_DRD) && (ph >= PH_STROBE0));
        wr_n    = !((c_q.kind == K_DWR) && (ph >= PH_STROBE0));
        ad_oe   = ((c_q.kind == K_FETCH) && (sph != PH_STROBE0)) ||
                  (is_data && (ph < PH_STROBE0)) ||
                  (c_q.kind == K_DWR);
        ad_out  = ((c_q.kind == K_DWR) && (ph >= PH_STROBE0)) ? c_q.wdata : c_q.lo;
        hi_addr = c_q.use_p2 ? p2_latch : c_q.hi;
    end

    assign rd_byte  = c_q.rbyte;
    assign rd_valid = c_q.rvalid;
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk (
    input logic clk,
    input logic arst_n,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe,
    input logic rd_valid,
    input logic core_rst,
    input logic mcyc_start
);
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!arst_n)
        !(!rd_n && !wr_n));

    a_r3_no_psen_in_data: assert property (@(posedge clk) disable iff (!arst_n)
        (!rd_n || !wr_n) |-> psen_n);

    a_r7_ale_before_release: assert property (@(posedge clk) disable iff (!arst_n)
        ($fell(ad_oe) && !mcyc_start) |-> (!ale && !$past(ale)));

    a_r8_write_drives_port: assert property (@(posedge clk) disable iff (!arst_n)
        !wr_n |-> ad_oe);

    a_r9_valid_single: assert property (@(posedge clk) disable iff (!arst_n)
        rd_valid |=> !rd_valid);

    a_r10_quiet_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
        core_rst |-> (!ale && psen_n && rd_n && wr_n));

    a_r4_psen_not_with_ale: assert property (@(posedge clk) disable iff (!arst_n)
        !psen_n |-> !ale);
endmodule

bind ext_bus_seq ext_bus_seq_chk chk_i (
    .clk        (clk),
    .arst_n     (arst_n),
    .ale        (ale),
    .psen_n     (psen_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .ad_oe      (ad_oe),
    .rd_valid   (rd_valid),
    .core_rst   (core_rst),
    .mcyc_start (mcyc_start)
);

// File: tb/ext_bus_seq_tb_top.sv
module ext_bus_seq_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        arst_n, mode6, ea_n, rst_pin, fetch_req, data_req, data_we, data_wide;
    logic [15:0] fetch_addr, data_addr;
    logic [7:0]  data_wdata, p2_latch, ad_in;
    logic        ale, psen_n, rd_n, wr_n, ad_oe, rd_valid, core_rst, mcyc_start;
    logic [7:0]  ad_out, hi_addr, rd_byte;

    ext_bus_seq dut_i (
        .clk(clk), .arst_n(arst_n), .mode6(mode6), .ea_n(ea_n), .rst_pin(rst_pin),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .data_req(data_req),
        .data_we(data_we), .data_wide(data_wide), .data_addr(data_addr),
        .data_wdata(data_wdata), .p2_latch(p2_latch), .ad_in(ad_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .hi_addr(hi_addr), .rd_byte(rd_byte), .rd_valid(rd_valid),
        .core_rst(core_rst), .mcyc_start(mcyc_start)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // {mode6, ea_n, fetch_req, data_req, data_we, data_wide}
    localparam int NV = 12;
    localparam logic [5:0] VEC [NV] = '{
        6'b001000, 6'b101000, 6'b011000, 6'b111000,
        6'b001101, 6'b001111, 6'b110100, 6'b101110,
        6'b000000, 6'b010110, 6'b101101, 6'b001000
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic to_start();
        @(negedge clk);
        while (!mcyc_start) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        arst_n = 1'b0; mode6 = 1'b0; ea_n = 1'b1; rst_pin = 1'b0;
        fetch_req = 1'b0; data_req = 1'b0; data_we = 1'b0; data_wide = 1'b0;
        fetch_addr = '0; data_addr = '0; data_wdata = '0; p2_latch = 8'h5A; ad_in = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 core_rst", 32'(core_rst), 1);
        chk("R11 strobes idle", {ale, psen_n, rd_n, wr_n}, 4'b0111);
        arst_n = 1'b1;
        @(negedge clk);
        chk("R11 ale quiet", 32'(ale), 0);
        to_start();
        chk("R11 core_rst clears", 32'(core_rst), 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic m6, ea, fr, dr, we, wd, data, ext;
            int n, L, ale_r, ale_h, ps, rd, wr, vc;
            logic prev_ale;
            logic [7:0] hi0, ad0, adl, vb;
            logic oe0, oel;
            {m6, ea, fr, dr, we, wd} = VEC[v];
            mode6 = m6; ea_n = ea; fetch_req = fr; data_req = dr; data_we = we; data_wide = wd;
            fetch_addr = {8'h70 + 8'(v), 8'h0F + 8'(v)};
            data_addr  = {8'hA0 + 8'(v), 8'h50 + 8'(v)};
            data_wdata = 8'h90 + 8'(v);
            p2_latch   = 8'h3C ^ 8'(v);
            ad_in      = 8'hC3 ^ 8'(v);
            to_start();
            L = m6 ? 1 : 2; n = 6 * L;
            ale_r = 0; ale_h = 0; ps = 0; rd = 0; wr = 0; vc = 0; prev_ale = 1'b0;
            hi0 = '0; ad0 = '0; adl = '0; vb = '0; oe0 = 1'b0; oel = 1'b0;
            for (int i = 0; i <= n; i++) begin
                if (i > 0) @(negedge clk);
                if (i < n) begin
                    if (ale && !prev_ale) ale_r++;
                    if (ale) ale_h++;
                    prev_ale = ale;
                    if (!psen_n) ps++;
                    if (!rd_n) rd++;
                    if (!wr_n) wr++;
                    if (i == 0) begin hi0 = hi_addr; ad0 = ad_out; oe0 = ad_oe; end
                    if (i == n - 1) begin adl = ad_out; oel = ad_oe; end
                end
                if (i >= 1 && rd_valid) begin vc++; vb = rd_byte; end
            end
            data = dr;
            ext  = !ea && fr && !data;
            chk("R1/R3 ale pulses", ale_r, data ? 1 : 2);
            chk("R1 ale width", ale_h, (data ? 1 : 2) * L);
            chk("R4/R5/R3 psen ticks", ps, ext ? 2 * L : 0);
            chk("R8 rd ticks", rd, (data && !we) ? 4 * L : 0);
            chk("R8 wr ticks", wr, (data && we) ? 4 * L : 0);
            chk("R6 hi_addr", hi0, data ? (wd ? data_addr[15:8] : p2_latch)
                                        : (ext ? fetch_addr[15:8] : p2_latch));
            if (data || ext) begin
                chk("R7 addr oe", 32'(oe0), 1);
                chk("R7 addr low", ad0, data ? data_addr[7:0] : fetch_addr[7:0]);
            end
            if (data && we) chk("R8 write byte", {oel, adl}, {1'b1, data_wdata});
            chk("R9 valid count", vc, ext ? 2 : ((data && !we) ? 1 : 0));
            if (vc > 0) chk("R9 byte", vb, ad_in);
        end
        data_req = 1'b0; fetch_req = 1'b0;

        // R2: mid-cycle mode change
        begin
            int len;
            mode6 = 1'b0;
            to_start(); to_start();
            repeat (3) @(negedge clk);
            mode6 = 1'b1;
            len = 3;
            @(negedge clk); len++;
            while (!mcyc_start) begin @(negedge clk); len++; end
            chk("R2 current cycle length", len, 12);
            len = 1;
            @(negedge clk);
            while (!mcyc_start) begin @(negedge clk); len++; end
            chk("R2 next cycle length", len, 6);
        end

        // R10: qualification
        rst_pin = 1'b1;
        for (int k = 1; k <= 7; k++) begin
            to_start();
            chk("R10 not yet", 32'(core_rst), 0);
        end
        to_start();
        chk("R10 asserted after 8", 32'(core_rst), 1);
        begin
            int ah = 0;
            ea_n = 1'b0; fetch_req = 1'b1;
            for (int i = 0; i < 6; i++) begin
                if (ale || !psen_n) ah++;
                @(negedge clk);
            end
            chk("R10 quiet bus", ah, 0);
        end
        rst_pin = 1'b0;
        to_start();
        chk("R10 released", 32'(core_rst), 0);
        rst_pin = 1'b1;
        for (int k = 1; k <= 7; k++) to_start();
        rst_pin = 1'b0;
        to_start();
        rst_pin = 1'b1;
        for (int k = 1; k <= 7; k++) to_start();
        chk("R10 count restarted", 32'(core_rst), 0);
        rst_pin = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule